// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is the arithmetic and logic stage of a small four-register processor. Each cycle in which `exec_en` is high, it takes a 4-bit operation code and two 8-bit operands (`opa_i` is the destination register value, `opb_i` the source). It computes add, subtract, AND, OR, XOR, single-bit shift left and right, low-byte multiply, integer divide or compare. On the next rising clock edge it registers the 8-bit result, a write-back strobe and four condition flags: zero, carry, negative and overflow.

Compare updates the flags and leaves the destination untouched. Subtract and compare report carry as "no borrow". A three-bit condition selector beside the ALU reads the stored flags and drives a branch-taken signal for the sequencer. When `exec_en` is low, or when the code is unassigned, the stored result and flags keep their values and no write-back is requested.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 is add. The result is (A+B) mod 256 and carry is the carry out of bit 7, so 255+1 gives result 0 with C=1 and Z=1.
- R2: Code 1 is subtract (A−B mod 256) and code 9 is compare. For both, C=1 when A ≥ B (no borrow) and C=0 when A < B.
- R3: After any operation that writes back, Z is 1 exactly when the 8-bit result is zero and N equals result bit 7; 0−1 gives 0xFF with N=1.
- R4: V flags two's-complement overflow for add and subtract. 127+1 sets V, 1+1 clears it, and 0x80−1 sets it.
- R5: Compare (code 9) updates Z, C, N and V as a subtract would, keeps `wr_en_q` low, and leaves `result_q` unchanged.
- R6: Codes 2, 3 and 4 are AND, OR and XOR. They set Z and N from the result and clear C and V.
- R7: Code 5 shifts A left by one and code 6 shifts A right by one, filling with zero; B is ignored. C takes the bit shifted out and V is cleared, so 0x65 shifted left gives 0xCA with C=0, and 0x80 shifted left gives 0 with C=1 and Z=1.
- R8: Code 7 returns the low 8 bits of A×B, with C=0 and V=0; 17×9 gives 153 and 16×16 gives 0 with Z=1.
- R9: Code 8 returns the integer quotient A/B with C=0 and V=0; 100/7 gives 14. A divisor of zero returns 0xFF with C=1.
- R10: `take_o` follows the stored flags according to `cond_sel_i`: 0 Z, 1 not Z, 2 C, 3 not C, 4 N, 5 not N, 6 V, 7 not V.
- R11: Outputs change one rising edge after an operation is presented with `exec_en` high. With `exec_en` low, or with codes 10 to 15, `wr_en_q` is 0 and the result and flags hold.
- R12: After reset the result is 0, `wr_en_q` is 0 and all four flags are 0, so condition 1 is taken and condition 0 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Destination operand A |
| opb_i | input | 8 | Source operand B |
| cond_sel_i | input | 3 | Branch condition selector |
| result_q | output | 8 | Registered result |
| wr_en_q | output | 1 | Result should be written to the destination register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow / shift-out / divide-error flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| take_o | output | 1 | Selected condition holds |

## Verification
Every stored value is visible at the ports one edge after the operation, so a wrong carry polarity, a missing overflow term or a compare that writes back shows at the very next sample. Flags are state. A flag that is wrongly updated by an idle cycle or an unassigned code only shows up later, through the held flag outputs and through `take_o` when a condition is selected. The bench therefore checks both the flags and the branch decision after idle gaps.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned OP_W   = 4;
    localparam int unsigned COND_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_MUL = 4'd7,
        OP_DIV = 4'd8,
        OP_CMP = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] quot,
    output logic         div_zero
);
    localparam int unsigned PW = 2 * W;
    logic [PW-1:0] prod;

    always_comb begin
        prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        prod_lo  = prod[W-1:0];
        div_zero = (b == '0);
        quot     = div_zero ? {W{1'b1}} : (a / b);
    end
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
    import alu8_pkg::*;
(
    input  flags_t              flags,
    input  logic [COND_W-1:0]   sel,
    output logic                take
);
    logic base;

    always_comb begin
        case (sel[COND_W-1:1])
            2'd0:    base = flags.z;
            2'd1:    base = flags.c;
            2'd2:    base = flags.n;
            default: base = flags.v;
        endcase
        take = base ^ sel[0];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec_en,
    input  logic [OP_W-1:0]      op_i,
    input  logic [W-1:0]         opa_i,
    input  logic [W-1:0]         opb_i,
    input  logic [COND_W-1:0]    cond_sel_i,
    output logic [W-1:0]         result_q,
    output logic                 wr_en_q,
    output logic                 flag_z,
    output logic                 flag_c,
    output logic                 flag_n,
    output logic                 flag_v,
    output logic                 take_o
);
    localparam int unsigned MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wr;
        flags_t       fl;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] as_sum, mul_lo, div_q;
    logic         as_cout, as_ovf, div_zero, is_sub;

    assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

    alu8_addsub #(.W(W)) u_addsub (
        .a(opa_i), .b(opb_i), .sub(is_sub),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu8_muldiv #(.W(W)) u_muldiv (
        .a(opa_i), .b(opb_i),
        .prod_lo(mul_lo), .quot(div_q), .div_zero(div_zero)
    );

    always_comb begin
        logic [W-1:0] r;
        logic         c, v, known, wb;
        r     = '0;
        c     = 1'b0;
        v     = 1'b0;
        known = 1'b1;
        wb    = 1'b1;
        case (op_i)
            OP_ADD, OP_SUB: begin r = as_sum; c = as_cout; v = as_ovf; end
            OP_CMP:         begin r = as_sum; c = as_cout; v = as_ovf; wb = 1'b0; end
            OP_AND:         r = opa_i & opb_i;
            OP_OR:          r = opa_i | opb_i;
            OP_XOR:         r = opa_i ^ opb_i;
            OP_SHL:         begin r = {opa_i[MSB-1:0], 1'b0}; c = opa_i[MSB]; end
            OP_SHR:         begin r = {1'b0, opa_i[MSB:1]};   c = opa_i[0];   end
            OP_MUL:         r = mul_lo;
            OP_DIV:         begin r = div_q; c = div_zero; end
            default:        begin known = 1'b0; wb = 1'b0; end
        endcase

        st_d    = st_q;
        st_d.wr = 1'b0;
        if (exec_en && known) begin
            st_d.wr   = wb;
            st_d.fl.z = (r == '0);
            st_d.fl.n = r[MSB];
            st_d.fl.c = c;
            st_d.fl.v = v;
            if (wb) begin
                st_d.res = r;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    alu8_cond u_cond (
        .flags(st_q.fl), .sel(cond_sel_i), .take(take_o)
    );

    assign result_q = st_q.res;
    assign wr_en_q  = st_q.wr;
    assign flag_z   = st_q.fl.z;
    assign flag_c   = st_q.fl.c;
    assign flag_n   = st_q.fl.n;
    assign flag_v   = st_q.fl.v;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exec_en,
    input logic [3:0]   op_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] result_q,
    input logic         wr_en_q,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_n,
    input logic         flag_v
);
    // R3
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (flag_n == result_q[W-1]) && (flag_z == (result_q == '0)));

    // R5
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_i == 4'd9) |=> (!wr_en_q && $stable(result_q)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en) |=> (!wr_en_q && $stable({result_q, flag_z, flag_c, flag_n, flag_v})));

    // R9
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_i == 4'd8 && opb_i == '0) |=> (result_q == {W{1'b1}} && flag_c));

    // R7
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_i == 4'd5) |=> (flag_c == $past(opa_i[W-1]) && !flag_v));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_q(result_q), .wr_en_q(wr_en_q),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] opa_i = '0, opb_i = '0;
    logic [2:0] cond_sel_i = '0;
    logic [7:0] result_q;
    logic       wr_en_q, flag_z, flag_c, flag_n, flag_v, take_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .cond_sel_i(cond_sel_i),
        .result_q(result_q), .wr_en_q(wr_en_q), .flag_z(flag_z),
        .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .take_o(take_o)
    );

    // Checks result, write strobe and flags {z,c,n,v} after one edge.
    task automatic chk(string req, logic [7:0] er, logic ew, logic [3:0] ef);
        total++;
        if (result_q !== er || wr_en_q !== ew || {flag_z, flag_c, flag_n, flag_v} !== ef) begin
            bad++;
            $display("FAIL %s: got res=%h wr=%b zcnv=%b, expected res=%h wr=%b zcnv=%b",
                     req, result_q, wr_en_q, {flag_z, flag_c, flag_n, flag_v}, er, ew, ef);
        end
    endtask

    task automatic run(logic en, logic [3:0] op, logic [7:0] a, logic [7:0] b);
        @(negedge clk);
        exec_en = en; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    task automatic chk_take(string req, logic [2:0] sel, logic exp);
        cond_sel_i = sel;
        #1;
        total++;
        if (take_o !== exp) begin
            bad++;
            $display("FAIL %s: sel=%0d take=%b expected %b", req, sel, take_o, exp);
        end
    endtask

    task automatic t_reset;
        chk("R12", 8'h00, 1'b0, 4'b0000);
        chk_take("R12", 3'd0, 1'b0);
        chk_take("R12", 3'd1, 1'b1);
    endtask

    task automatic t_add;
        run(1, 4'd0, 8'd255, 8'd1);  chk("R1", 8'h00, 1, 4'b1100);
        run(1, 4'd0, 8'd127, 8'd1);  chk("R4", 8'h80, 1, 4'b0011);
        run(1, 4'd0, 8'd1, 8'd1);    chk("R4", 8'h02, 1, 4'b0000);
    endtask

    task automatic t_sub;
        run(1, 4'd1, 8'd0, 8'd1);    chk("R3", 8'hFF, 1, 4'b0010);
        run(1, 4'd1, 8'd5, 8'd5);    chk("R2", 8'h00, 1, 4'b1100);
        run(1, 4'd1, 8'h80, 8'd1);   chk("R4", 8'h7F, 1, 4'b0101);
    endtask

    task automatic t_cmp;
        run(1, 4'd0, 8'd40, 8'd2);   chk("R5", 8'd42, 1, 4'b0000);
        run(1, 4'd9, 8'd3, 8'd5);    chk("R5", 8'd42, 0, 4'b0010);
        run(1, 4'd9, 8'd7, 8'd7);    chk("R2", 8'd42, 0, 4'b1100);
    endtask

    task automatic t_logic;
        run(1, 4'd0, 8'd255, 8'd1);  // leave C set
        run(1, 4'd2, 8'hCC, 8'hF0);  chk("R6", 8'hC0, 1, 4'b0010);
        run(1, 4'd3, 8'hC0, 8'h0F);  chk("R6", 8'hCF, 1, 4'b0010);
        run(1, 4'd4, 8'hCF, 8'hAA);  chk("R6", 8'h65, 1, 4'b0000);
        run(1, 4'd4, 8'h5A, 8'h5A);  chk("R6", 8'h00, 1, 4'b1000);
    endtask

    task automatic t_shift;
        run(1, 4'd5, 8'h65, 8'hFF);  chk("R7", 8'hCA, 1, 4'b0010);
        run(1, 4'd5, 8'h80, 8'h00);  chk("R7", 8'h00, 1, 4'b1100);
        run(1, 4'd6, 8'hCA, 8'h00);  chk("R7", 8'h65, 1, 4'b0000);
        run(1, 4'd6, 8'h01, 8'h55);  chk("R7", 8'h00, 1, 4'b1100);
    endtask

    task automatic t_muldiv;
        run(1, 4'd7, 8'd17, 8'd9);   chk("R8", 8'd153, 1, 4'b0010);
        run(1, 4'd7, 8'd16, 8'd16);  chk("R8", 8'd0, 1, 4'b1000);
        run(1, 4'd8, 8'd100, 8'd7);  chk("R9", 8'd14, 1, 4'b0000);
        run(1, 4'd8, 8'd9, 8'd0);    chk("R9", 8'hFF, 1, 4'b0110);
        run(1, 4'd8, 8'd3, 8'd9);    chk("R9", 8'd0, 1, 4'b1000);
    endtask

    task automatic t_hold;
        run(1, 4'd0, 8'd127, 8'd1);  chk("R11", 8'h80, 1, 4'b0011);
        run(0, 4'd0, 8'd0, 8'd0);    chk("R11", 8'h80, 0, 4'b0011);
        run(1, 4'd12, 8'd0, 8'd0);   chk("R11", 8'h80, 0, 4'b0011);
        run(1, 4'd15, 8'd1, 8'd1);   chk("R11", 8'h80, 0, 4'b0011);
    endtask

    task automatic t_cond;
        // flags z=0 c=0 n=1 v=1 from previous step
        chk_take("R10", 3'd0, 0); chk_take("R10", 3'd1, 1);
        chk_take("R10", 3'd2, 0); chk_take("R10", 3'd3, 1);
        chk_take("R10", 3'd4, 1); chk_take("R10", 3'd5, 0);
        chk_take("R10", 3'd6, 1); chk_take("R10", 3'd7, 0);
        run(1, 4'd0, 8'd255, 8'd1);  // z=1 c=1 n=0 v=0
        chk_take("R10", 3'd0, 1); chk_take("R10", 3'd1, 0);
        chk_take("R10", 3'd2, 1); chk_take("R10", 3'd3, 0);
        chk_take("R10", 3'd4, 0); chk_take("R10", 3'd5, 1);
        chk_take("R10", 3'd6, 0); chk_take("R10", 3'd7, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_shift();
        t_muldiv();
        t_hold();
        t_cond();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule